// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers level-style interrupt requests from up to 26 peripheral lines into two 16-bit first-level pending registers. Each pending register has a 16-bit enable mask. One CPU interrupt request is raised whenever any enabled first-level pending bit is set. A second group of 32 general-purpose I/O request lines has its own 32-bit pending and mask pair. Its combined request is registered and wired internally onto one first-level line, so the I/O group cascades into the first level.

Software reaches all six registers over a simple synchronous register bus. A read is returned one cycle after it is issued. A write to a pending register clears each bit written as one, and masks are plain storage. Both interrupt outputs are registered. They are recomputed on every clock edge from the state that edge produces, so a mask write or a pending clear takes effect at the edge that performs the access.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Input `irq_i[i]` with i from 0 to 15 sets bit i of pending register 1 (offset 0x80). Input i from 16 to 25 sets bit i-16 of pending register 2 (offset 0xA0). Bits 10 to 15 of pending register 2 always read 0.
- R2: After each clock edge, `cpu_irq_o` is 1 exactly when (pending1 AND mask1) OR (pending2 AND mask2) is nonzero for the register contents produced by that edge.
- R3: A write to offset 0x80 or 0xA0 clears each pending bit whose `wdata_i` bit is 1 and leaves the other bits unchanged. If a line rises in the same cycle as such a write, the set wins.
- R4: Mask 1 (offset 0x8C) and mask 2 (offset 0xA6) are 16-bit read/write registers. A read returns the low 16 bits of the last write, and bits 16 to 31 read as 0.
- R5: Each of the 32 lines `gpio_irq_i[j]` sets bit j of the second-level pending register (offset 0x88). The second-level mask is at offset 0x94 and is 32 bits wide. After each edge, `gpio_irq_o` is 1 exactly when second-level pending AND mask is nonzero.
- R6: A write to offset 0x88 clears each second-level pending bit written as 1 and leaves the others unchanged.
- R7: `gpio_irq_o` drives first-level line CASC_LINE (default 8) in place of `irq_i[CASC_LINE]`, which is ignored. The cascaded pending bit sets on the edge after `gpio_irq_o` rises.
- R8: A pending bit is set on the edge at which its line is seen high after being low. A line that stays high does not set the bit again after software clears it. A pending bit is cleared on any edge at which its line is low.
- R9: `rdata_o` presents, one cycle after `rd_en_i`, the value the addressed register held before that edge, even when a write to it happens in the same cycle. `rdata_o` is 0 in a cycle that follows no read.
- R10: A read of any offset other than the six listed returns 0. A write to such an offset changes no register.
- R11: Synchronous reset clears all pending and mask registers and sets `cpu_irq_o`, `gpio_irq_o` and `rdata_o` to 0.
- R12: A mask write, or a pending clear that removes the last enabled request, changes `cpu_irq_o` at the same edge that updates the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_L1 (26) | First-level peripheral request lines |
| gpio_irq_i | input | NUM_L2 (32) | Second-level I/O request lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, one cycle after the read |
| cpu_irq_o | output | 1 | Registered CPU interrupt request |
| gpio_irq_o | output | 1 | Registered second-level combined request |

## Verification
The bench builds the block with its default parameters: 26 first-level lines, 32 second-level lines, 16-bit first-level registers, and the cascade placed on line 8. With these values the cascade lands inside pending register 1, next to ordinary peripheral bits, so cascade and direct requests can be mixed in one mask. Pending register 2 is only partly populated, so the upper bits that can never be set are exercised as well. Random line activity and random accesses, including accesses to an unmapped offset, run together with directed cases for a clear that meets a set in the same cycle, a read that meets a write in the same cycle, and a line that is held high after being cleared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NREG   = 6;
  localparam int IX_P1  = 0;
  localparam int IX_L2P = 1;
  localparam int IX_M1  = 2;
  localparam int IX_L2M = 3;
  localparam int IX_P2  = 4;
  localparam int IX_M2  = 5;

  // Byte offsets seen by software; the decode depends on these values.
  function automatic logic [7:0] reg_offset(input int ix);
    case (ix)
      IX_P1:   reg_offset = 8'h80;
      IX_L2P:  reg_offset = 8'h88;
      IX_M1:   reg_offset = 8'h8C;
      IX_L2M:  reg_offset = 8'h94;
      IX_P2:   reg_offset = 8'hA0;
      IX_M2:   reg_offset = 8'hA6;
      default: reg_offset = 8'h00;
    endcase
  endfunction

  // First-level bank b is cleared by this pending register.
  function automatic int bank_pend_ix(input int b);
    bank_pend_ix = (b == 0) ? IX_P1 : IX_P2;
  endfunction

  // First-level bank b is enabled by this mask register.
  function automatic int bank_mask_ix(input int b);
    bank_mask_ix = (b == 0) ? IX_M1 : IX_M2;
  endfunction
endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_o[i] = (addr_i == ADDR_W'(reg_offset(i)));
  end
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic         hit_o
);
  logic [W-1:0] lines_q, pend_q, mask_q;
  logic [W-1:0] rise, clr, pend_n, mask_n;

  always_comb begin
    rise   = lines_i & ~lines_q;
    clr    = clr_we_i ? wdata_i : '0;
    pend_n = ((pend_q & ~clr) | rise) & lines_i;
    mask_n = mask_we_i ? wdata_i : mask_q;
  end

  // Request seen by the output registers, aligned with the new state.
  assign hit_o = |(pend_n & mask_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
    end else begin
      lines_q <= lines_i;
      pend_q  <= pend_n;
      mask_q  <= mask_n;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_L1    = 26,
  parameter int L1_W      = 16,
  parameter int NUM_L2    = 32,
  parameter int CASC_LINE = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_L1-1:0] irq_i,
  input  logic [NUM_L2-1:0] gpio_irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cpu_irq_o,
  output logic              gpio_irq_o
);
  localparam int NBANK = 2;
  localparam int PAD_W = NBANK * L1_W;

  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   we;
  logic [PAD_W-1:0]  l1_lines;
  logic [L1_W-1:0]   pend_l1 [NBANK];
  logic [L1_W-1:0]   mask_l1 [NBANK];
  logic [NBANK-1:0]  bank_hit;
  logic [NUM_L2-1:0] l2_pend, l2_mask;
  logic              l2_hit;
  logic              giu_q, cpu_q;
  logic [DATA_W-1:0] rsel, rdata_q;
  logic [L1_W-1:0]   p1_w, p2_w, m1_w, m2_w;

  irqc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign we = hit & {NREG{wr_en_i}};

  // Second-level group.
  irqc_pend_bank #(.W(NUM_L2)) u_l2 (
    .clk       (clk),
    .rst       (rst),
    .lines_i   (gpio_irq_i),
    .clr_we_i  (we[IX_L2P]),
    .mask_we_i (we[IX_L2M]),
    .wdata_i   (wdata_i[NUM_L2-1:0]),
    .pend_o    (l2_pend),
    .mask_o    (l2_mask),
    .hit_o     (l2_hit)
  );

  // First-level line vector, padded, with the cascade substituted.
  always_comb begin
    l1_lines              = '0;
    l1_lines[NUM_L1-1:0]  = irq_i;
    l1_lines[CASC_LINE]   = giu_q;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_l1
    irqc_pend_bank #(.W(L1_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .lines_i   (l1_lines[b*L1_W +: L1_W]),
      .clr_we_i  (we[bank_pend_ix(b)]),
      .mask_we_i (we[bank_mask_ix(b)]),
      .wdata_i   (wdata_i[L1_W-1:0]),
      .pend_o    (pend_l1[b]),
      .mask_o    (mask_l1[b]),
      .hit_o     (bank_hit[b])
    );
  end

  assign p1_w = pend_l1[0];
  assign p2_w = pend_l1[1];
  assign m1_w = mask_l1[0];
  assign m2_w = mask_l1[1];

  always_comb begin
    rsel = '0;
    if (hit[IX_P1])  rsel = DATA_W'(p1_w);
    if (hit[IX_P2])  rsel = DATA_W'(p2_w);
    if (hit[IX_M1])  rsel = DATA_W'(m1_w);
    if (hit[IX_M2])  rsel = DATA_W'(m2_w);
    if (hit[IX_L2P]) rsel = DATA_W'(l2_pend);
    if (hit[IX_L2M]) rsel = DATA_W'(l2_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      giu_q   <= 1'b0;
      cpu_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      giu_q   <= l2_hit;
      cpu_q   <= |bank_hit;
      rdata_q <= rd_en_i ? rsel : '0;
    end
  end

  assign rdata_o    = rdata_q;
  assign cpu_irq_o  = cpu_q;
  assign gpio_irq_o = giu_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_L1 = 26,
  parameter int L1_W   = 16,
  parameter int NUM_L2 = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cpu_irq_o,
  input logic              gpio_irq_o,
  input logic [L1_W-1:0]   p1_w,
  input logic [L1_W-1:0]   p2_w,
  input logic [L1_W-1:0]   m1_w,
  input logic [L1_W-1:0]   m2_w,
  input logic [NUM_L2-1:0] l2_pend,
  input logic [NUM_L2-1:0] l2_mask,
  input logic [2*L1_W-1:0] l1_lines
);
  localparam int HI_USED = NUM_L1 - L1_W;

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == ADDR_W'(reg_offset(i))) mapped = 1'b1;
  end

  // R2
  p_cpu_level_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o == (|((p1_w & m1_w) | (p2_w & m2_w))));

  // R5
  p_gpio_level_r5: assert property (@(posedge clk) disable iff (rst)
    gpio_irq_o == (|(l2_pend & l2_mask)));

  // R8: no pending bit survives an edge at which its line was low
  p_clear_low_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((({p2_w, p1_w}) & ~$past(l1_lines)) == '0));

  // R4
  p_mask_rw_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(reg_offset(IX_M1))) |=>
      (m1_w == $past(wdata_i[L1_W-1:0])));

  // R10
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !mapped) |=> (rdata_o == '0));

  // R9
  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rdata_o == '0));

  // R1
  p_p2_unused_r1: assert property (@(posedge clk) disable iff (rst)
    (p2_w >> HI_USED) == '0);
endmodule

bind irq_cascade_ctrl irqc_checker #(
  .NUM_L1 (NUM_L1),
  .L1_W   (L1_W),
  .NUM_L2 (NUM_L2),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .cpu_irq_o  (cpu_irq_o),
  .gpio_irq_o (gpio_irq_o),
  .p1_w       (p1_w),
  .p2_w       (p2_w),
  .m1_w       (m1_w),
  .m2_w       (m2_w),
  .l2_pend    (l2_pend),
  .l2_mask    (l2_mask),
  .l1_lines   (l1_lines)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;
  localparam int CASC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] irq = '0;
  logic [31:0] gio = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu_irq, gpio_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Model state, derived from the requirements.
  logic [15:0] m_p1 = '0, m_p2 = '0, m_m1 = '0, m_m2 = '0;
  logic [31:0] m_l2p = '0, m_l2m = '0, m_l2prev = '0;
  logic [31:0] m_l1prev = '0;
  logic        m_giu = 0, m_cpu = 0;
  logic [31:0] m_rd = '0;

  irq_cascade_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_i(irq), .gpio_irq_i(gio),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cpu_irq_o(cpu_irq), .gpio_irq_o(gpio_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] regval(input logic [7:0] a);
    case (a)
      8'h80:   regval = {16'h0, m_p1};
      8'h88:   regval = m_l2p;
      8'h8C:   regval = {16'h0, m_m1};
      8'h94:   regval = m_l2m;
      8'hA0:   regval = {16'h0, m_p2};
      8'hA6:   regval = {16'h0, m_m2};
      default: regval = '0;
    endcase
  endfunction

  // One clock with the current drives; update model; compare at negedge.
  task automatic cyc();
    logic [31:0] lines, rise, clr;
    @(posedge clk);
    m_rd = rd ? regval(addr) : '0;
    // second level
    rise  = gio & ~m_l2prev;
    clr   = (wr && addr == 8'h88) ? wdata : '0;
    m_l2p = ((m_l2p & ~clr) | rise) & gio;
    m_l2prev = gio;
    if (wr && addr == 8'h94) m_l2m = wdata;
    // first level, cascade from previous output
    lines = {6'h0, irq};
    lines[CASC] = m_giu;
    rise  = lines & ~m_l1prev;
    clr   = '0;
    if (wr && addr == 8'h80) clr[15:0]  = wdata[15:0];
    if (wr && addr == 8'hA0) clr[31:16] = wdata[15:0];
    {m_p2, m_p1} = (({m_p2, m_p1} & ~clr) | rise) & lines;
    m_l1prev = lines;
    if (wr && addr == 8'h8C) m_m1 = wdata[15:0];
    if (wr && addr == 8'hA6) m_m2 = wdata[15:0];
    m_giu = |(m_l2p & m_l2m);
    m_cpu = |((m_p1 & m_m1) | (m_p2 & m_m2));
    @(negedge clk);
    chk(cpu_irq === m_cpu, "R2 cpu_irq", {31'h0, cpu_irq}, {31'h0, m_cpu});
    chk(gpio_irq === m_giu, "R5 gpio_irq", {31'h0, gpio_irq}, {31'h0, m_giu});
    chk(rdata === m_rd, "R9 rdata", rdata, m_rd);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    cyc();
    wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] exp,
                        input string tag);
    rd = 1; addr = a;
    cyc();
    rd = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [7];
    logic [31:0] r;
    offs = '{8'h80, 8'h88, 8'h8C, 8'h94, 8'hA0, 8'hA6, 8'h90};
    r = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11: reset state
    chk(cpu_irq === 0, "R11 cpu after reset", {31'h0, cpu_irq}, 0);
    chk(gpio_irq === 0, "R11 gpio after reset", {31'h0, gpio_irq}, 0);
    chk(rdata === 0, "R11 rdata after reset", rdata, 0);
    foreach (offs[i]) rd_reg(offs[i], 32'h0, "R11 register cleared");

    // R4: masks
    wr_reg(8'h8C, 32'hFFFF_1234);
    rd_reg(8'h8C, 32'h0000_1234, "R4 mask1 readback");
    wr_reg(8'hA6, 32'h0000_00FF);
    rd_reg(8'hA6, 32'h0000_00FF, "R4 mask2 readback");

    // R1: line mapping
    irq[3] = 1; cyc();
    rd_reg(8'h80, 32'h0000_0008, "R1 line3 in pending1");
    chk(cpu_irq === 0, "R2 masked off", {31'h0, cpu_irq}, 0);
    wr_reg(8'h8C, 32'h0000_0008);
    chk(cpu_irq === 1, "R12 mask write raises cpu", {31'h0, cpu_irq}, 1);
    irq[20] = 1; cyc();
    rd_reg(8'hA0, 32'h0000_0010, "R1 line20 in pending2");

    // R3 / R12: clear drops request at the write edge
    wr_reg(8'hA6, 32'h0);
    wr_reg(8'h80, 32'h0000_0008);
    chk(cpu_irq === 0, "R12 clear drops cpu", {31'h0, cpu_irq}, 0);
    rd_reg(8'h80, 32'h0, "R8 held line not re-set after clear");
    rd_reg(8'hA0, 32'h0000_0010, "R3 other register untouched");

    // R8: low clears, new rise sets
    irq[3] = 0; irq[20] = 0; cyc();
    rd_reg(8'hA0, 32'h0, "R8 low line clears pending2");
    irq[3] = 1; cyc();
    rd_reg(8'h80, 32'h0000_0008, "R8 new rise sets pending1");

    // R10: unmapped offsets
    wr_reg(8'h84, 32'hFFFF_FFFF);
    rd_reg(8'h84, 32'h0, "R10 unmapped read zero");
    rd_reg(8'h8C, 32'h0000_0008, "R10 unmapped write ignored");

    // R7: cascade, direct input at the cascade index ignored
    irq[CASC] = 1;
    wr_reg(8'h8C, 32'h0000_0100);
    rd_reg(8'h80, 32'h0000_0008, "R7 direct input at cascade line ignored");
    gio[5] = 1;
    wr_reg(8'h94, 32'h0000_0020);
    chk(gpio_irq === 1, "R5 gpio request", {31'h0, gpio_irq}, 1);
    chk(cpu_irq === 0, "R7 cascade one edge later", {31'h0, cpu_irq}, 0);
    cyc();
    chk(cpu_irq === 1, "R7 cascade raises cpu", {31'h0, cpu_irq}, 1);
    rd_reg(8'h80, 32'h0000_0108, "R7 cascade bit in pending1");
    rd_reg(8'h88, 32'h0000_0020, "R5 second-level pending");

    // R6: second-level clear, cascade bit then drops
    wr_reg(8'h88, 32'h0000_0020);
    chk(gpio_irq === 0, "R6 clear drops gpio", {31'h0, gpio_irq}, 0);
    cyc();
    chk(cpu_irq === 0, "R6 cascade bit cleared", {31'h0, cpu_irq}, 0);
    rd_reg(8'h88, 32'h0, "R6 second-level pending cleared");

    // R3: set wins over clear in the same cycle
    irq[0] = 1;
    wr_reg(8'h80, 32'h0000_0001);
    rd_reg(8'h80, 32'h0000_0009, "R3 rise beats clear");

    // R9: read and write of the same register in one cycle
    wr = 1; rd = 1; addr = 8'h8C; wdata = 32'h0000_ABCD;
    cyc();
    wr = 0; rd = 0;
    chk(rdata === 32'h0000_0100, "R9 read returns old value", rdata, 32'h100);
    rd_reg(8'h8C, 32'h0000_ABCD, "R9 write landed");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      int op;
      if ($urandom_range(7) == 0) irq[$urandom_range(25)] ^= 1'b1;
      if ($urandom_range(7) == 0) gio[$urandom_range(31)] ^= 1'b1;
      op = $urandom_range(3);
      addr  = offs[$urandom_range(6)];
      wdata = $urandom();
      wr = (op == 0);
      rd = (op == 1);
      cyc();
      wr = 0; rd = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule